// File: doc/BRIEF.md
# Calendar Real-Time Clock with Alarm

This block keeps wall-clock time as seven separate fields: a two-digit year, month, day of month, day of week, hour, minute and second. It advances by one second on each cycle where the one-pulse-per-second `tickEn` input is high. Software reaches it through a plain 32-bit register bus. The bus has an address, a write strobe, write data and a combinational read-data return.

The counter stays frozen after reset. It starts only once seven fixed key bytes have been written to their key locations. A stop bit also lets software hold the count while it loads a new time.

A second bank of seven alarm fields is compared against the running time. The alarm control register holds a global enable and one compare-select bit per field. When the selected fields become equal after a tick, a sticky status bit is set. An interrupt line follows that status while the alarm is enabled.

Top module: `cal_rtc`

## Requirements
- R1: After reset, `irqOut` is 0 and the status, stop, alarm control and debounce registers read 0. Time fields read year 0, month 1, day of month 1, and 0 for day of week, hour, minute and second. Alarm fields read 0.
- R2: The counter advances on a tick only while all seven keys hold their values: 0xC6 at 0x04, 0x9A at 0x08, 0x59 at 0x0C, 0xA3 at 0x10, 0x57 at 0x14, 0x67 at 0x18 and 0xD2 at 0x1C (byte in bits 7:0). The keys may be written in any order. Writing any other value to a key location relocks that key.
- R3: Bit 0 of the register at 0x20 is a stop bit; while it is 1 ticks are ignored. A write to a time field loads bits 6:0 on the next clock edge, and wins over a tick in the same cycle.
- R4: Seconds and minutes count 0..59 and hours count 0..23, each carrying into the next field. On a day change, day of week counts 0..6 and wraps to 0.
- R5: Day of month wraps to 1 after 30 days in months 4, 6, 9 and 11, and after 31 days in the other months. February has 29 days when the year is a nonzero multiple of 4 and 28 otherwise, so year 0 is not leap. Month 12 wraps to 1 and carries into the year, and year 99 wraps to 0.
- R6: Time field i sits at 0x40+4i and alarm field i at 0x60+4i, in the order year, month, day of month, day of week, hour, minute, second. Reads return the value zero-extended to 32 bits.
- R7: In the alarm control register at 0x7C, bit 0 enables the alarm and bit 1+i selects field i for comparison. One cycle after a tick commits a new time, status bit 4 of 0x30 is set if the alarm is enabled, all selected fields match, and they did not match at the previous check. Any write to the alarm fields or the alarm control register re-arms this edge.
- R8: The status bit is sticky. Writing 1 to bit 4 of 0x30 clears it, and writing 0 to that bit leaves it unchanged.
- R9: `irqOut` is the status bit ANDed with alarm enable bit 0. Writing 0 to 0x7C drops `irqOut` and leaves the status readable.
- R10: Bits 2:0 of 0x2C are plain read/write storage, and its other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Register byte address |
| busWe | input | 1 | Write strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr` |
| tickEn | input | 1 | One-second advance enable |
| irqOut | output | 1 | Alarm interrupt |

## Verification
The hardest case to reach from the ports is a full carry through every field: the second, minute, hour, day, month and year must all roll over on a single tick. Leap and non-leap Februaries and the year-99 wrap make this harder still.

The bench unlocks the counter, sets the stop bit, and loads a time one second before the boundary. It then clears the stop bit and issues exactly one tick, walking a table of such start and expected-end times.

The edge-only alarm rule is reached by leaving a selected field equal across consecutive ticks after clearing the status, and then checking that the status stays clear.

// File: rtl/cal_rtc_pkg.sv
package cal_rtc_pkg;
  localparam int NUM_FIELDS = 7;
  localparam int FIELD_W    = 7;
  localparam int NUM_KEYS   = 7;

  localparam int IDX_YEAR = 0;
  localparam int IDX_MON  = 1;
  localparam int IDX_DOM  = 2;
  localparam int IDX_DOW  = 3;
  localparam int IDX_HOUR = 4;
  localparam int IDX_MIN  = 5;
  localparam int IDX_SEC  = 6;

  localparam logic [7:0] OFS_STOP  = 8'h20;
  localparam logic [7:0] OFS_DEB   = 8'h2C;
  localparam logic [7:0] OFS_INT   = 8'h30;
  localparam logic [7:0] OFS_ALCTL = 8'h7C;
  localparam int STATUS_BIT = 4;

  typedef struct packed {
    logic               advance;
    logic               timeWr;
    logic               alarmWr;
    logic [2:0]         idx;
    logic [FIELD_W-1:0] data;
  } dp_strobe_t;

  function automatic logic [7:0] keyValue(input int k);
    case (k)
      0: keyValue = 8'hC6;
      1: keyValue = 8'h9A;
      2: keyValue = 8'h59;
      3: keyValue = 8'hA3;
      4: keyValue = 8'h57;
      5: keyValue = 8'h67;
      default: keyValue = 8'hD2;
    endcase
  endfunction

  function automatic logic [FIELD_W-1:0] resetValue(input int i);
    resetValue = (i == IDX_MON || i == IDX_DOM) ? FIELD_W'(1) : '0;
  endfunction

  function automatic logic [FIELD_W-1:0] daysIn(input logic [FIELD_W-1:0] mon,
                                                input logic [FIELD_W-1:0] yr);
    logic leap;
    leap = (yr != 0) && (yr[1:0] == 2'b00);
    case (mon)
      7'd2:                     daysIn = leap ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:  daysIn = 7'd30;
      default:                  daysIn = 7'd31;
    endcase
  endfunction
endpackage

// File: rtl/cal_rtc_dp.sv
module cal_rtc_dp
  import cal_rtc_pkg::*;
#(
  parameter int FW = FIELD_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dp_strobe_t            stb,
  input  logic [NUM_FIELDS-1:0] cmpSel,
  input  logic                  rdBank,
  input  logic [2:0]            rdIdx,
  output logic [FW-1:0]         rdField,
  output logic                  matchNow
);
  logic [FW-1:0] tm  [NUM_FIELDS];
  logic [FW-1:0] al  [NUM_FIELDS];
  logic [FW-1:0] nxt [NUM_FIELDS];
  logic secWrap, minWrap, hourWrap, domWrap, monWrap, dayCarry;
  logic [NUM_FIELDS-1:0] fieldOk;

  // Calendar carry chain
  always_comb begin
    for (int i = 0; i < NUM_FIELDS; i++) nxt[i] = tm[i];
    secWrap  = tm[IDX_SEC]  >= FW'(59);
    minWrap  = tm[IDX_MIN]  >= FW'(59);
    hourWrap = tm[IDX_HOUR] >= FW'(23);
    domWrap  = tm[IDX_DOM]  >= daysIn(tm[IDX_MON], tm[IDX_YEAR]);
    monWrap  = tm[IDX_MON]  >= FW'(12);
    dayCarry = secWrap && minWrap && hourWrap;
    nxt[IDX_SEC] = secWrap ? '0 : tm[IDX_SEC] + FW'(1);
    if (secWrap) nxt[IDX_MIN] = minWrap ? '0 : tm[IDX_MIN] + FW'(1);
    if (secWrap && minWrap) nxt[IDX_HOUR] = hourWrap ? '0 : tm[IDX_HOUR] + FW'(1);
    if (dayCarry) begin
      nxt[IDX_DOW] = (tm[IDX_DOW] >= FW'(6)) ? '0 : tm[IDX_DOW] + FW'(1);
      nxt[IDX_DOM] = domWrap ? FW'(1) : tm[IDX_DOM] + FW'(1);
      if (domWrap) begin
        nxt[IDX_MON] = monWrap ? FW'(1) : tm[IDX_MON] + FW'(1);
        if (monWrap)
          nxt[IDX_YEAR] = (tm[IDX_YEAR] >= FW'(99)) ? '0 : tm[IDX_YEAR] + FW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_FIELDS; i++) begin
        tm[i] <= resetValue(i);
        al[i] <= '0;
      end
    end else begin
      if (stb.advance)
        for (int i = 0; i < NUM_FIELDS; i++) tm[i] <= nxt[i];
      if (stb.timeWr && stb.idx < 3'(NUM_FIELDS)) tm[stb.idx] <= stb.data;
      if (stb.alarmWr && stb.idx < 3'(NUM_FIELDS)) al[stb.idx] <= stb.data;
    end
  end

  generate
    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_cmp
      assign fieldOk[g] = !cmpSel[g] || (tm[g] == al[g]);
    end
  endgenerate
  assign matchNow = &fieldOk;

  always_comb begin
    rdField = '0;
    if (rdIdx < 3'(NUM_FIELDS)) rdField = rdBank ? al[rdIdx] : tm[rdIdx];
  end

  // R4: seconds step by one below the wrap point
  a_r4_sec_step: assert property (@(posedge clk) disable iff (!rstN)
    (stb.advance && !stb.timeWr && tm[IDX_SEC] < FW'(59)) |=> tm[IDX_SEC] == $past(tm[IDX_SEC]) + FW'(1));
  // R4: seconds wrap at 59
  a_r4_sec_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (stb.advance && !stb.timeWr && tm[IDX_SEC] == FW'(59)) |=> tm[IDX_SEC] == '0);
  // R3: without advance or write the time holds
  a_r3_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.advance && !stb.timeWr) |=> ($stable(tm[IDX_SEC]) && $stable(tm[IDX_YEAR])));
  // R5: day of month never leaves 1..31 after an advance
  a_r5_dom_range: assert property (@(posedge clk) disable iff (!rstN)
    (stb.advance && !stb.timeWr && tm[IDX_DOM] >= FW'(1) && tm[IDX_DOM] <= FW'(31))
      |=> (tm[IDX_DOM] >= FW'(1) && tm[IDX_DOM] <= FW'(31)));
endmodule

// File: rtl/cal_rtc_ctrl.sv
module cal_rtc_ctrl
  import cal_rtc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int DEB_W  = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic                  busWe,
  input  logic [DATA_W-1:0]     busWdata,
  output logic [DATA_W-1:0]     busRdata,
  input  logic                  tickEn,
  output logic                  irqOut,
  output dp_strobe_t            stb,
  output logic [NUM_FIELDS-1:0] cmpSel,
  output logic                  rdBank,
  output logic [2:0]            rdIdx,
  input  logic [FIELD_W-1:0]    rdField,
  input  logic                  matchNow
);
  localparam int CTL_W = NUM_FIELDS + 1;

  logic [7:0] addr8;
  logic isKey, isField, isStop, isDeb, isInt, isAlCtl;
  logic [2:0] keyIdx;
  logic [NUM_KEYS-1:0] keyOk;
  logic unlocked, stopBit, statusBit, checkStb, prevMatch;
  logic [DEB_W-1:0] debReg;
  logic [CTL_W-1:0] alCtl;
  logic setHit, clrHit;

  assign addr8   = 8'(busAddr);
  assign isKey   = addr8[7:5] == 3'b000 && addr8[4:2] != 3'd0 && addr8[1:0] == 2'b00;
  assign keyIdx  = addr8[4:2] - 3'd1;
  assign isField = addr8[7:6] == 2'b01 && addr8[4:2] != 3'd7 && addr8[1:0] == 2'b00;
  assign isStop  = addr8 == OFS_STOP;
  assign isDeb   = addr8 == OFS_DEB;
  assign isInt   = addr8 == OFS_INT;
  assign isAlCtl = addr8 == OFS_ALCTL;
  assign rdBank  = addr8[5];
  assign rdIdx   = addr8[4:2];

  generate
    for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
      always_ff @(posedge clk) begin
        if (!rstN) keyOk[k] <= 1'b0;
        else if (busWe && isKey && keyIdx == 3'(k))
          keyOk[k] <= busWdata[7:0] == keyValue(k);
      end
    end
  endgenerate
  assign unlocked = &keyOk;

  always_comb begin
    stb.advance = tickEn && unlocked && !stopBit;
    stb.timeWr  = busWe && isField && !rdBank;
    stb.alarmWr = busWe && isField && rdBank;
    stb.idx     = addr8[4:2];
    stb.data    = busWdata[FIELD_W-1:0];
  end

  assign cmpSel = alCtl[CTL_W-1:1];
  assign setHit = checkStb && alCtl[0] && matchNow && !prevMatch;
  assign clrHit = busWe && isInt && busWdata[STATUS_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stopBit   <= 1'b0;
      debReg    <= '0;
      alCtl     <= '0;
      statusBit <= 1'b0;
      checkStb  <= 1'b0;
      prevMatch <= 1'b0;
    end else begin
      checkStb <= stb.advance;
      if (busWe && isStop)  stopBit <= busWdata[0];
      if (busWe && isDeb)   debReg  <= busWdata[DEB_W-1:0];
      if (busWe && isAlCtl) alCtl   <= busWdata[CTL_W-1:0];
      if (stb.alarmWr || (busWe && isAlCtl)) prevMatch <= 1'b0;
      else if (checkStb)                     prevMatch <= matchNow;
      if (setHit)      statusBit <= 1'b1;
      else if (clrHit) statusBit <= 1'b0;
    end
  end

  assign irqOut = statusBit && alCtl[0];

  always_comb begin
    busRdata = '0;
    if (isField)      busRdata = DATA_W'(rdField);
    else if (isStop)  busRdata = DATA_W'(stopBit);
    else if (isDeb)   busRdata = DATA_W'(debReg);
    else if (isInt)   busRdata[STATUS_BIT] = statusBit;
    else if (isAlCtl) busRdata = DATA_W'(alCtl);
  end

  // R8: status stays set unless a clearing write arrives
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (statusBit && !clrHit) |=> statusBit);
  // R7: status rises only in the cycle after a committed tick
  a_r7_after_tick: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusBit) |-> $past(checkStb));
  // R9: the interrupt only falls through a bus write
  a_r9_fall_by_write: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqOut) |-> $past(busWe));
  // R2: a tick while locked leaves no check strobe behind
  a_r2_locked: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && !unlocked) |=> !checkStb);
endmodule

// File: rtl/cal_rtc.sv
module cal_rtc
  import cal_rtc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              tickEn,
  output logic              irqOut
);
  dp_strobe_t            stb;
  logic [NUM_FIELDS-1:0] cmpSel;
  logic                  rdBank;
  logic [2:0]            rdIdx;
  logic [FIELD_W-1:0]    rdField;
  logic                  matchNow;

  cal_rtc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .tickEn(tickEn),
    .irqOut(irqOut), .stb(stb), .cmpSel(cmpSel), .rdBank(rdBank),
    .rdIdx(rdIdx), .rdField(rdField), .matchNow(matchNow)
  );

  cal_rtc_dp #(.FW(FIELD_W)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .cmpSel(cmpSel), .rdBank(rdBank),
    .rdIdx(rdIdx), .rdField(rdField), .matchNow(matchNow)
  );
endmodule

// File: tb/sim_cal_rtc.sv
module sim_cal_rtc;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        tickEn = 1'b0;
  logic        irqOut;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  cal_rtc u0 (.clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
              .busWdata(busWdata), .busRdata(busRdata), .tickEn(tickEn),
              .irqOut(irqOut));

  // start {year,mon,dom,dow,hour,min,sec}, expected after one tick (same order)
  localparam int NV = 12;
  localparam logic [97:0] VECS [NV] = '{
    {7'd5,7'd3,7'd10,7'd2,7'd4,7'd5,7'd6,      7'd5,7'd3,7'd10,7'd2,7'd4,7'd5,7'd7},
    {7'd5,7'd3,7'd10,7'd2,7'd4,7'd5,7'd59,     7'd5,7'd3,7'd10,7'd2,7'd4,7'd6,7'd0},
    {7'd5,7'd3,7'd10,7'd2,7'd23,7'd59,7'd59,   7'd5,7'd3,7'd11,7'd3,7'd0,7'd0,7'd0},
    {7'd5,7'd3,7'd10,7'd6,7'd23,7'd59,7'd59,   7'd5,7'd3,7'd11,7'd0,7'd0,7'd0,7'd0},
    {7'd5,7'd4,7'd30,7'd3,7'd23,7'd59,7'd59,   7'd5,7'd5,7'd1,7'd4,7'd0,7'd0,7'd0},
    {7'd5,7'd1,7'd31,7'd3,7'd23,7'd59,7'd59,   7'd5,7'd2,7'd1,7'd4,7'd0,7'd0,7'd0},
    {7'd4,7'd2,7'd28,7'd3,7'd23,7'd59,7'd59,   7'd4,7'd2,7'd29,7'd4,7'd0,7'd0,7'd0},
    {7'd5,7'd2,7'd28,7'd3,7'd23,7'd59,7'd59,   7'd5,7'd3,7'd1,7'd4,7'd0,7'd0,7'd0},
    {7'd0,7'd2,7'd28,7'd3,7'd23,7'd59,7'd59,   7'd0,7'd3,7'd1,7'd4,7'd0,7'd0,7'd0},
    {7'd4,7'd2,7'd29,7'd3,7'd23,7'd59,7'd59,   7'd4,7'd3,7'd1,7'd4,7'd0,7'd0,7'd0},
    {7'd12,7'd12,7'd31,7'd3,7'd23,7'd59,7'd59, 7'd13,7'd1,7'd1,7'd4,7'd0,7'd0,7'd0},
    {7'd99,7'd12,7'd31,7'd3,7'd23,7'd59,7'd59, 7'd0,7'd1,7'd1,7'd4,7'd0,7'd0,7'd0}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk); busWe = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); busAddr = a; busWe = 1'b0;
    #1 d = busRdata;
  endtask

  task automatic tick();
    @(negedge clk); tickEn = 1'b1;
    @(negedge clk); tickEn = 1'b0;
  endtask

  task automatic unlockAll();
    wr(8'h04, 32'hC6); wr(8'h08, 32'h9A); wr(8'h0C, 32'h59); wr(8'h10, 32'hA3);
    wr(8'h14, 32'h57); wr(8'h18, 32'h67); wr(8'h1C, 32'hD2);
  endtask

  task automatic loadTime(input logic [48:0] t);
    wr(8'h20, 32'h1);
    for (int i = 0; i < 7; i++) wr(8'(8'h40 + 4 * i), 32'(t[48 - 7 * i -: 7]));
    wr(8'h20, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    chk("R1 irq", 32'(irqOut), 0);
    rd(8'h30, d); chk("R1 status", d, 0);
    rd(8'h20, d); chk("R1 stop", d, 0);
    rd(8'h7C, d); chk("R1 alctl", d, 0);
    rd(8'h2C, d); chk("R1 debounce", d, 0);
    rd(8'h48, d); chk("R1 dom", d, 1);
    rd(8'h44, d); chk("R1 month", d, 1);
    rd(8'h58, d); chk("R1 sec", d, 0);
    rd(8'h78, d); chk("R1 alarm sec", d, 0);

    // R2 locked: ticks ignored until all keys written
    tick(); rd(8'h58, d); chk("R2 locked no keys", d, 0);
    wr(8'h1C, 32'hD2); wr(8'h18, 32'h67); wr(8'h14, 32'h57);
    wr(8'h10, 32'hA3); wr(8'h0C, 32'h59); wr(8'h08, 32'h9A);
    tick(); rd(8'h58, d); chk("R2 six keys", d, 0);
    wr(8'h04, 32'hC6);
    tick(); rd(8'h58, d); chk("R2 unlocked any order", d, 1);
    wr(8'h10, 32'h00);
    tick(); rd(8'h58, d); chk("R2 relock wrong value", d, 1);
    unlockAll();
    tick(); rd(8'h58, d); chk("R2 unlocked again", d, 2);

    // R3 stop bit and field load
    wr(8'h20, 32'h1); rd(8'h20, d); chk("R3 stop readback", d, 1);
    tick(); rd(8'h58, d); chk("R3 stopped", d, 2);
    wr(8'h58, 32'd40); rd(8'h58, d); chk("R3 load", d, 40);
    wr(8'h20, 32'h0);
    tick(); rd(8'h58, d); chk("R3 running", d, 41);

    // R4 R5 R6 table of rollovers
    for (int v = 0; v < NV; v++) begin
      loadTime(VECS[v][97:49]);
      tick();
      for (int i = 0; i < 7; i++) begin
        rd(8'(8'h40 + 4 * i), d);
        chk($sformatf("R4/R5 vec %0d field %0d (R6 address)", v, i), d, 32'(VECS[v][48 - 7 * i -: 7]));
      end
    end

    // R7 alarm on second
    loadTime({7'd5,7'd3,7'd10,7'd2,7'd4,7'd5,7'd6});
    wr(8'h78, 32'd8);
    rd(8'h78, d); chk("R6 alarm readback", d, 8);
    wr(8'h7C, 32'h81);
    tick(); rd(8'h30, d); chk("R7 no match yet", d, 0);
    tick(); rd(8'h30, d); chk("R7 match status", d, 32'h10);
    chk("R9 irq on", 32'(irqOut), 1);
    tick(); rd(8'h30, d); chk("R8 sticky", d, 32'h10);
    wr(8'h30, 32'h0); rd(8'h30, d); chk("R8 write 0 no clear", d, 32'h10);
    wr(8'h30, 32'h10); rd(8'h30, d); chk("R8 w1c", d, 0);
    chk("R9 irq off after clear", 32'(irqOut), 0);

    // R7 edge rule: minute-only compare stays equal over ticks
    wr(8'h74, 32'd5);
    wr(8'h7C, 32'h41);
    tick(); rd(8'h30, d); chk("R7 minute match", d, 32'h10);
    wr(8'h30, 32'h10);
    tick(); rd(8'h30, d); chk("R7 no refire while equal", d, 0);

    // R9 mask by writing 0 to alarm control
    wr(8'h7C, 32'hFF);
    wr(8'h78, 32'd20); wr(8'h74, 32'd5); wr(8'h70, 32'd4);
    wr(8'h6C, 32'd2); wr(8'h68, 32'd10); wr(8'h64, 32'd3); wr(8'h60, 32'd5);
    wr(8'h7C, 32'hFF);
    loadTime({7'd5,7'd3,7'd10,7'd2,7'd4,7'd5,7'd19});
    tick(); rd(8'h30, d); chk("R7 all fields match", d, 32'h10);
    chk("R9 irq all", 32'(irqOut), 1);
    wr(8'h7C, 32'h0);
    chk("R9 masked irq", 32'(irqOut), 0);
    rd(8'h30, d); chk("R9 status kept", d, 32'h10);
    wr(8'h30, 32'h10);

    // R10 debounce storage
    wr(8'h2C, 32'hFFFF_FFFF); rd(8'h2C, d); chk("R10 debounce", d, 7);
    wr(8'h2C, 32'h5); rd(8'h2C, d); chk("R10 debounce 5", d, 5);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule